// File: doc/BRIEF.md
# Receive-Side Flow-Control Pause Engine

This block sits behind the receive MAC of a full-duplex Ethernet port. It watches every incoming frame byte by byte and decides at the end of each frame whether the frame is a well-formed pause request. A frame qualifies when its destination matches the reserved flow-control multicast address, its type field and opcode match, its length is at least the Ethernet minimum and the upstream CRC checker reports a good FCS. The two-byte argument of an accepted request loads a countdown of pause quanta. Each quantum is 512 bit times, counted from a bit-time tick input. While the countdown is non-zero, a transmit-hold level tells the local transmitter to stop. The hold level only changes while the transmitter is between frames.

The receive stream also passes through a short fixed delay line of 14 bytes. This delay lets the type field be known before the first byte of a frame leaves the block. Frames carrying the control type are removed whole. All other frames come out unchanged, with their start, end and FCS flags.

Top module: `pause_rx_ctl`

## Requirements
- R1: A frame is accepted as a pause request when all of the following hold: bytes 0..5 are 01 80 C2 00 00 01, bytes 12..13 are 88 08, bytes 14..15 are 00 01, the eof byte has rx_fcs_ok high, and the frame is at least 64 bytes. An accepted frame raises pause_seen for exactly one cycle, in the cycle after its eof byte.
- R2: A frame that fails only the destination, type or FCS test produces no pause_seen pulse and leaves tx_hold unchanged.
- R3: A frame shorter than 64 bytes is never accepted, even with every field correct.
- R4: An accepted argument q (bytes 16..17, most significant byte first) keeps tx_hold high for exactly q×512 bit_tick pulses. tx_hold falls within three cycles of the last of those pulses.
- R5: An accepted argument of zero ends the paused state at once. tx_hold is low two cycles after the pause_seen pulse.
- R6: An accepted request during a pause replaces the remaining time with its own value. The two times are not added.
- R7: tx_hold changes only on cycles where tx_busy is low, so a frame being transmitted always completes.
- R8: A control-type frame with an opcode other than 0001 changes nothing and is not forwarded.
- R9: Frames with type 88 08 never appear on the out_* stream. Every other frame appears byte for byte in order, with one out_sof, one out_eof and its FCS flag.
- R10: When a request is accepted in the same cycle as a bit_tick, the load wins. The new count starts from a full, fresh quantum.
- R11: After reset, tx_hold, pause_seen and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid; contiguous within a frame |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame (FCS included) |
| rx_fcs_ok | input | 1 | FCS check result, valid with rx_eof |
| bit_tick | input | 1 | One pulse per line bit time |
| tx_busy | input | 1 | Local transmitter is inside a frame |
| tx_hold | output | 1 | Inhibit new transmissions |
| pause_seen | output | 1 | One-cycle strobe per accepted pause request |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | Forwarded first byte |
| out_eof | output | 1 | Forwarded last byte |
| out_fcs_ok | output | 1 | Forwarded FCS result |

## Verification
The countdown can receive a new load in the same cycle as a bit tick that advances its quantum counter. The bench provokes this by holding bit_tick high on every cycle while a first short pause runs and a second request arrives. The load therefore always lands on a tick with a part-used quantum. The result is judged by the exact cycle in which tx_hold falls: it must match a count of three full quanta from the strobe. A stale sub-count or an added remainder moves that edge. Forwarding and classification also overlap, because the type decision and the delayed release of the first byte meet in the same cycle. Dropped and passed frames are both compared byte by byte.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam logic [47:0] FC_DEST    = 48'h0180C2000001;
  localparam logic [15:0] FC_TYPE    = 16'h8808;
  localparam logic [15:0] FC_OPCODE  = 16'h0001;
  localparam int          MIN_LEN    = 64;
  localparam int          OFF_TYPE   = 12;
  localparam int          OFF_OPCODE = 14;
  localparam int          OFF_ARG    = 16;
  localparam int          HDR_DELAY  = OFF_TYPE + 2;

  typedef struct packed {
    logic       v;
    logic       sof;
    logic       eof;
    logic       fcs;
    logic [7:0] d;
  } beat_t;
endpackage

// File: rtl/pause_parse.sv
module pause_parse #(
  parameter int CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_fcs_ok,
  output logic        ld,
  output logic [15:0] ld_val,
  output logic        ctl_type
);
  import pause_pkg::*;

  localparam logic [CNT_W-1:0] I_TYPE_HI = CNT_W'(OFF_TYPE);
  localparam logic [CNT_W-1:0] I_TYPE_LO = CNT_W'(OFF_TYPE + 1);
  localparam logic [CNT_W-1:0] I_OP_HI   = CNT_W'(OFF_OPCODE);
  localparam logic [CNT_W-1:0] I_OP_LO   = CNT_W'(OFF_OPCODE + 1);
  localparam logic [CNT_W-1:0] I_ARG_HI  = CNT_W'(OFF_ARG);
  localparam logic [CNT_W-1:0] I_ARG_LO  = CNT_W'(OFF_ARG + 1);
  localparam logic [CNT_W-1:0] I_LAST_MIN = CNT_W'(MIN_LEN - 1);
  localparam logic [CNT_W-1:0] I_DA_END  = CNT_W'(6);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, idx;
  logic             da_q, da_nx;
  logic [7:0]       exp_b;
  logic [15:0]      typ_q, op_q, arg_q;
  logic             accept;

  always_comb begin
    idx   = in_sof ? '0 : cnt_q;
    exp_b = '0;
    for (int i = 0; i < 6; i++)
      if (idx == CNT_W'(i)) exp_b = FC_DEST[8*(5-i) +: 8];
    da_nx  = (in_sof ? 1'b1 : da_q) & ((idx < I_DA_END) ? (in_data == exp_b) : 1'b1);
    accept = in_eof && da_nx && (typ_q == FC_TYPE) && (op_q == FC_OPCODE)
             && in_fcs_ok && (idx >= I_LAST_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      da_q     <= 1'b0;
      typ_q    <= '0;
      op_q     <= '0;
      arg_q    <= '0;
      ld       <= 1'b0;
      ld_val   <= '0;
      ctl_type <= 1'b0;
    end else begin
      ld <= 1'b0;
      if (in_valid) begin
        cnt_q <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        da_q  <= da_nx;
        if (idx == I_TYPE_HI) typ_q[15:8] <= in_data;
        if (idx == I_TYPE_LO) typ_q[7:0]  <= in_data;
        if (idx == I_OP_HI)   op_q[15:8]  <= in_data;
        if (idx == I_OP_LO)   op_q[7:0]   <= in_data;
        if (idx == I_ARG_HI)  arg_q[15:8] <= in_data;
        if (idx == I_ARG_LO)  arg_q[7:0]  <= in_data;
        if (in_sof) ctl_type <= 1'b0;
        if (idx == I_TYPE_LO && typ_q[15:8] == FC_TYPE[15:8] && in_data == FC_TYPE[7:0])
          ctl_type <= 1'b1;
        if (accept) begin
          ld     <= 1'b1;
          ld_val <= arg_q;
        end
      end
    end
  end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int QW      = 16,
  parameter int QUANTUM = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [QW-1:0] ld_val,
  input  logic          tick,
  output logic [QW-1:0] quanta,
  output logic          active
);
  localparam int            SW       = $clog2(QUANTUM);
  localparam logic [SW-1:0] SUB_LAST = SW'(QUANTUM - 1);

  logic [SW-1:0] sub_q;

  assign active = |quanta;

  always_ff @(posedge clk) begin
    if (rst) begin
      quanta <= '0;
      sub_q  <= '0;
    end else if (ld) begin
      quanta <= ld_val;
      sub_q  <= '0;
    end else if (tick && active) begin
      if (sub_q == SUB_LAST) begin
        sub_q  <= '0;
        quanta <= quanta - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_filter.sv
module ctl_filter #(
  parameter int DLY = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_fcs_ok,
  input  logic        drop_flag,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_fcs_ok
);
  import pause_pkg::*;

  beat_t pipe [DLY];
  beat_t head;
  logic  drop_q, drop_sel;

  assign head     = pipe[DLY-1];
  assign drop_sel = head.sof ? drop_flag : drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY; i++) pipe[i] <= '0;
      drop_q     <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_fcs_ok <= 1'b0;
    end else begin
      pipe[0] <= '{v: in_valid, sof: in_sof, eof: in_eof, fcs: in_fcs_ok, d: in_data};
      for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
      if (head.v && head.sof) drop_q <= drop_flag;
      out_valid  <= head.v && !drop_sel;
      out_data   <= head.d;
      out_sof    <= head.v && head.sof && !drop_sel;
      out_eof    <= head.v && head.eof && !drop_sel;
      out_fcs_ok <= head.fcs;
    end
  end
endmodule

// File: rtl/pause_rx_ctl.sv
module pause_rx_ctl #(
  parameter int CNT_W   = 11,
  parameter int QW      = 16,
  parameter int QUANTUM = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_fcs_ok,
  input  logic       bit_tick,
  input  logic       tx_busy,
  output logic       tx_hold,
  output logic       pause_seen,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_fcs_ok
);
  import pause_pkg::*;

  logic          pause_ld;
  logic [15:0]   pause_val;
  logic          is_ctl;
  logic [QW-1:0] quanta;
  logic          timer_active;

  pause_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .in_eof(rx_eof), .in_fcs_ok(rx_fcs_ok),
    .ld(pause_ld), .ld_val(pause_val), .ctl_type(is_ctl)
  );

  pause_timer #(.QW(QW), .QUANTUM(QUANTUM)) u_timer (
    .clk(clk), .rst(rst), .ld(pause_ld), .ld_val(QW'(pause_val)),
    .tick(bit_tick), .quanta(quanta), .active(timer_active)
  );

  ctl_filter #(.DLY(HDR_DELAY)) u_filter (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .in_eof(rx_eof), .in_fcs_ok(rx_fcs_ok),
    .drop_flag(is_ctl), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_fcs_ok(out_fcs_ok)
  );

  assign pause_seen = pause_ld;

  always_ff @(posedge clk) begin
    if (rst)          tx_hold <= 1'b0;
    else if (!tx_busy) tx_hold <= timer_active;
  end
endmodule

// File: rtl/pause_rx_ctl_chk.sv
module pause_rx_ctl_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_eof,
  input logic          rx_fcs_ok,
  input logic          tx_busy,
  input logic          tx_hold,
  input logic          pause_seen,
  input logic [15:0]   ld_val,
  input logic [QW-1:0] quanta,
  input logic          active
);
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    pause_seen |=> !pause_seen);

  assert_strobe_after_good_eof_R1: assert property (@(posedge clk) disable iff (rst)
    pause_seen |-> $past(rx_valid && rx_eof && rx_fcs_ok));

  assert_hold_frozen_busy_R7: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_hold));

  assert_reload_replaces_R6: assert property (@(posedge clk) disable iff (rst)
    pause_seen |=> (quanta == QW'($past(ld_val))));

  assert_zero_ends_pause_R5: assert property (@(posedge clk) disable iff (rst)
    (pause_seen && ld_val == 16'h0) |=> !active);

  assert_count_never_rises_R4: assert property (@(posedge clk) disable iff (rst)
    (!pause_seen && active) |=> (quanta <= $past(quanta)));
endmodule

bind pause_rx_ctl pause_rx_ctl_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .rx_fcs_ok(rx_fcs_ok), .tx_busy(tx_busy), .tx_hold(tx_hold),
  .pause_seen(pause_seen), .ld_val(pause_val), .quanta(quanta),
  .active(timer_active)
);

// File: tb/sim_pause_rx_ctl.sv
`timescale 1ns/1ps
module sim_pause_rx_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_fcs_ok = 0;
  logic [7:0] rx_data = '0;
  logic bit_tick = 0, tx_busy = 0;
  logic tx_hold, pause_seen, out_valid, out_sof, out_eof, out_fcs_ok;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  int mon_n = 0, sofs = 0, eofs = 0, seen_n = 0;
  logic last_fcs = 0;
  logic [7:0] mon_buf [256];

  localparam logic [47:0] GOOD_DA = 48'h0180C2000001;

  always #10 clk = ~clk;

  pause_rx_ctl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
    .bit_tick(bit_tick), .tx_busy(tx_busy), .tx_hold(tx_hold),
    .pause_seen(pause_seen), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_fcs_ok(out_fcs_ok)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      mon_buf[mon_n % 256] = out_data;
      mon_n++;
      if (out_sof) sofs++;
      if (out_eof) begin eofs++; last_fcs = out_fcs_ok; end
    end
    if (pause_seen) seen_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
      input logic [15:0] ty, input logic [15:0] op, input logic [15:0] arg);
    if (i < 6)  return da[8*(5-i) +: 8];
    if (i < 12) return 8'(8'h20 + i);
    if (i == 12) return ty[15:8];
    if (i == 13) return ty[7:0];
    if (i == 14) return op[15:8];
    if (i == 15) return op[7:0];
    if (i == 16) return arg[15:8];
    if (i == 17) return arg[7:0];
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                      input logic [15:0] arg, input int len, input bit fcs);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid  = 1;
      rx_sof    = (i == 0);
      rx_eof    = (i == len - 1);
      rx_fcs_ok = (i == len - 1) ? fcs : 1'b0;
      rx_data   = fbyte(i, da, ty, op, arg);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0; rx_data = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pause();
    send(GOOD_DA, 16'h8808, 16'h0001, 16'h0000, 64, 1);
    wait_n(3);
  endtask

  task automatic t_reset();
    chk(tx_hold == 0, "R11 tx_hold", tx_hold, 0);
    chk(pause_seen == 0, "R11 pause_seen", pause_seen, 0);
    chk(out_valid == 0, "R11 out_valid", out_valid, 0);
  endtask

  task automatic t_accept();
    int s0 = seen_n, m0 = mon_n;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd200, 64, 1);
    chk(pause_seen == 1, "R1 strobe after eof", pause_seen, 1);
    wait_n(1);
    chk(pause_seen == 0, "R1 strobe one cycle", pause_seen, 0);
    wait_n(2);
    chk(tx_hold == 1, "R1 hold asserted", tx_hold, 1);
    wait_n(20);
    chk(seen_n - s0 == 1, "R1 strobe count", seen_n - s0, 1);
    chk(mon_n == m0, "R9 pause not forwarded", mon_n - m0, 0);
    clear_pause();
  endtask

  task automatic t_reject();
    int s0 = seen_n;
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'd100, 64, 1);
    send(GOOD_DA, 16'h8809, 16'h0001, 16'd100, 64, 1);
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd100, 64, 0);
    wait_n(20);
    chk(seen_n == s0, "R2 no strobe on bad field", seen_n - s0, 0);
    chk(tx_hold == 0, "R2 hold unchanged", tx_hold, 0);
  endtask

  task automatic t_runt();
    int s0 = seen_n;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd100, 63, 1);
    wait_n(20);
    chk(seen_n == s0, "R3 runt no strobe", seen_n - s0, 0);
    chk(tx_hold == 0, "R3 runt no hold", tx_hold, 0);
  endtask

  task automatic t_count();
    bit_tick = 0;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd2, 64, 1);
    wait_n(3);
    chk(tx_hold == 1, "R4 hold on load", tx_hold, 1);
    for (int i = 0; i < 1023; i++) begin @(negedge clk); bit_tick = 1; end
    @(negedge clk); bit_tick = 0;
    wait_n(3);
    chk(tx_hold == 1, "R4 hold before last tick", tx_hold, 1);
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
    wait_n(2);
    chk(tx_hold == 0, "R4 hold after q*512 ticks", tx_hold, 0);
  endtask

  task automatic t_zero();
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd500, 64, 1);
    wait_n(3);
    chk(tx_hold == 1, "R5 hold before zero", tx_hold, 1);
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd0, 64, 1);
    chk(pause_seen == 1, "R5 zero frame accepted", pause_seen, 1);
    wait_n(2);
    chk(tx_hold == 0, "R5 zero clears at once", tx_hold, 0);
  endtask

  task automatic t_unknown_op();
    int s0, m0;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd300, 64, 1);
    wait_n(3);
    s0 = seen_n; m0 = mon_n;
    send(GOOD_DA, 16'h8808, 16'h0002, 16'd0, 64, 1);
    wait_n(25);
    chk(tx_hold == 1, "R8 unknown opcode keeps pause", tx_hold, 1);
    chk(seen_n == s0, "R8 no strobe", seen_n - s0, 0);
    chk(mon_n == m0, "R8 not forwarded", mon_n - m0, 0);
    clear_pause();
  endtask

  task automatic t_busy();
    tx_busy = 1;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd100, 64, 1);
    wait_n(5);
    chk(tx_hold == 0, "R7 hold waits for boundary", tx_hold, 0);
    tx_busy = 0;
    wait_n(2);
    chk(tx_hold == 1, "R7 hold at boundary", tx_hold, 1);
    tx_busy = 1;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd0, 64, 1);
    wait_n(5);
    chk(tx_hold == 1, "R7 release waits", tx_hold, 1);
    tx_busy = 0;
    wait_n(2);
    chk(tx_hold == 0, "R7 release at boundary", tx_hold, 0);
  endtask

  task automatic t_reload_tick();
    bit_tick = 1;
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd1, 64, 1);
    wait_n(30);
    send(GOOD_DA, 16'h8808, 16'h0001, 16'd3, 64, 1);
    chk(pause_seen == 1, "R6 reload strobe", pause_seen, 1);
    wait_n(1537);
    chk(tx_hold == 1, "R6 R10 hold through full reload", tx_hold, 1);
    wait_n(1);
    chk(tx_hold == 0, "R10 load beats tick, exact end", tx_hold, 0);
    bit_tick = 0;
  endtask

  task automatic t_forward();
    int m0 = mon_n, sf0 = sofs, ef0 = eofs, bad = 0;
    send(48'h00AABBCCDDEE, 16'h0800, 16'h1234, 16'h5678, 70, 1);
    wait_n(25);
    chk(mon_n - m0 == 70, "R9 forwarded length", mon_n - m0, 70);
    for (int i = 0; i < 70; i++)
      if (mon_buf[(m0 + i) % 256] !== fbyte(i, 48'h00AABBCCDDEE, 16'h0800, 16'h1234, 16'h5678)) bad++;
    chk(bad == 0, "R9 forwarded bytes", bad, 0);
    chk(sofs - sf0 == 1 && eofs - ef0 == 1, "R9 sof/eof", (sofs - sf0) * 10 + (eofs - ef0), 11);
    chk(last_fcs == 1, "R9 fcs flag", last_fcs, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 0;
    wait_n(1);
    t_reset();
    t_accept();
    t_reject();
    t_runt();
    t_count();
    t_zero();
    t_unknown_op();
    t_busy();
    t_reload_tick();
    t_forward();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule